// File: doc/BRIEF.md
# Four-Channel Supply Qualification Sequencer

This block is the digital timing and reporting logic of a multi-rail undervoltage supervisor. Each channel receives one comparator bit that is high while its monitored rail sits above threshold. The block synchronizes these bits and the enable input. It reports a channel as good only after its input has held high without a break for a long qualification window. It reports the channel as bad again only after the input has stayed low for longer than a short glitch window.

A registered power-good flag is the AND of all channel statuses. When one channel drops out, only that channel's status falls, together with power-good. The other channels keep their status, and power-good is revalidated once the failed channel requalifies. Driving the enable input low clears every status and power-good. Channels that a parameter marks as unused count as permanently valid. Both window lengths are parameters in clock cycles.

Top module: `supply_supervisor_seq`

## Requirements
- R1: While reset is asserted, every channel status and power-good read 0.
- R2: A channel status rises only after QUAL_CYCLES consecutive high samples of its synchronized input. An input that goes high between edges n and n+1 gives a status of 1 after edge n+2+QUAL_CYCLES, and the status is still 0 after edge n+1+QUAL_CYCLES.
- R3: A single low sample during qualification restarts the window. Counting begins again from the next high sample.
- R4: A good channel falls after GLITCH_CYCLES consecutive low samples. An input that goes low between edges n and n+1 gives a status of 0 after edge n+2+GLITCH_CYCLES.
- R5: A low pulse shorter than GLITCH_CYCLES samples leaves the status high. Each such pulse starts from a cleared glitch count, so repeated short dips are also ignored.
- R6: Power-good is 1 only when all statuses are 1. It rises one clock after the last status rises.
- R7: Power-good falls on the same clock edge as any status falls.
- R8: A failing channel clears only its own status. The other statuses stay 1 while their own inputs stay valid.
- R9: Enable low clears all statuses and power-good on the third edge after enable falls, and the rail inputs are ignored while enable is low.
- R10: When enable rises with all inputs valid, the statuses rise on edge n+2+QUAL_CYCLES and power-good rises one edge later.
- R11: A channel whose USED_MASK bit is 0 is treated as always valid, whatever its rail input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Monitoring enable; tie high when unused |
| rail_ok_i | input | NUM_CH | Comparator bits, 1 = rail above threshold |
| chan_good_o | output | NUM_CH | Per-channel qualified status |
| power_good_o | output | 1 | Registered AND of all statuses |

## Verification
Two functions can fall on the same edge: one channel finishing its qualification window while another channel's glitch window expires. The bench times a recovering channel's rise and a second channel's falling input so that both filters complete on the same edge. It then requires that power-good does not rise on that edge or on the next one, and that each status takes its own new value. A second case covers a status fall and the power-good fall, which the bench compares on the same edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic {
    CH_WAIT = 1'b0,
    CH_GOOD = 1'b1
  } ch_state_e;

  // Counter width able to hold values 0 .. limit-1
  function automatic int ctr_width(input int limit);
    return (limit < 2) ? 1 : $clog2(limit);
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // True when the current sample completes a window of 'limit' samples
  function automatic logic window_done(input logic [31:0] cnt,
                                       input logic [31:0] limit);
    return (cnt + 32'd1) >= limit;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/sup_chan_filter.sv
module sup_chan_filter
  import sup_pkg::*;
#(
  parameter int QUAL_CYCLES   = 16,
  parameter int GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rail_i,
  output logic good_o,
  output logic good_nxt_o,
  output logic qual_done_o,
  output logic glitch_done_o
);

  localparam int CW = ctr_width(max2(QUAL_CYCLES, GLITCH_CYCLES));
  localparam logic [31:0] QUAL_LIM   = 32'(QUAL_CYCLES);
  localparam logic [31:0] GLITCH_LIM = 32'(GLITCH_CYCLES);

  ch_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        toward_change;
  logic [31:0] limit;
  logic        hit;

  // A sample counts toward a state change when it disagrees with the state
  assign toward_change = (state_q == CH_WAIT) ? rail_i : !rail_i;
  assign limit         = (state_q == CH_WAIT) ? QUAL_LIM : GLITCH_LIM;
  assign hit           = toward_change && window_done(32'(cnt_q), limit);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!en_i) begin
      state_d = CH_WAIT;
      cnt_d   = '0;
    end else if (toward_change) begin
      if (hit) begin
        state_d = (state_q == CH_WAIT) ? CH_GOOD : CH_WAIT;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_WAIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign good_o        = (state_q == CH_GOOD);
  assign good_nxt_o    = (state_d == CH_GOOD);
  assign qual_done_o   = en_i && (state_q == CH_WAIT) && hit;
  assign glitch_done_o = en_i && (state_q == CH_GOOD) && hit;

endmodule

// File: rtl/sup_pg_combine.sv
module sup_pg_combine #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] good_i,
  input  logic [NUM_CH-1:0] good_nxt_i,
  output logic              pg_o
);

  // Rising needs all statuses already high; falling follows next state at once
  logic pg_d;
  assign pg_d = (&good_i) && (&good_nxt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_o <= 1'b0;
    else        pg_o <= pg_d;
  end

endmodule

// File: rtl/supply_supervisor_seq.sv
module supply_supervisor_seq #(
  parameter int                NUM_CH        = 4,
  parameter int                QUAL_CYCLES   = 8_000_000,
  parameter int                GLITCH_CYCLES = 1500,
  parameter int                SYNC_STAGES   = 2,
  parameter logic [NUM_CH-1:0] USED_MASK     = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [NUM_CH-1:0] rail_ok_i,
  output logic [NUM_CH-1:0] chan_good_o,
  output logic              power_good_o
);

  localparam int SW = NUM_CH + 1;

  logic [SW-1:0]     synced;
  logic              en_sync;
  logic [NUM_CH-1:0] rail_sync;
  logic [NUM_CH-1:0] rail_eff;
  logic [NUM_CH-1:0] good_nxt;
  logic [NUM_CH-1:0] qual_done;
  logic [NUM_CH-1:0] glitch_done;

  sup_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({enable_i, rail_ok_i}),
    .q     (synced)
  );

  assign en_sync   = synced[NUM_CH];
  assign rail_sync = synced[NUM_CH-1:0];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (USED_MASK[i]) begin : g_used
      assign rail_eff[i] = rail_sync[i];
    end else begin : g_unused
      assign rail_eff[i] = 1'b1;
    end

    sup_chan_filter #(
      .QUAL_CYCLES   (QUAL_CYCLES),
      .GLITCH_CYCLES (GLITCH_CYCLES)
    ) u_filt (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en_sync),
      .rail_i        (rail_eff[i]),
      .good_o        (chan_good_o[i]),
      .good_nxt_o    (good_nxt[i]),
      .qual_done_o   (qual_done[i]),
      .glitch_done_o (glitch_done[i])
    );
  end

  sup_pg_combine #(.NUM_CH(NUM_CH)) u_pg (
    .clk        (clk),
    .rst_n      (rst_n),
    .good_i     (chan_good_o),
    .good_nxt_i (good_nxt),
    .pg_o       (power_good_o)
  );

endmodule

// File: rtl/sup_checker.sv
module sup_checker #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_sync,
  input logic [NUM_CH-1:0] rail_eff,
  input logic [NUM_CH-1:0] chan_good,
  input logic              power_good,
  input logic [NUM_CH-1:0] qual_done,
  input logic [NUM_CH-1:0] glitch_done
);

  logic edge_seen = 1'b0;
  always @(posedge clk) edge_seen <= 1'b1;

  always @(negedge clk) begin
    if (!rst_n && edge_seen)
      AST_RESET_CLEAR: assert (chan_good == '0 && !power_good); // R1
  end

  AST_PG_NEEDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> (&chan_good)); // R6

  AST_PG_RISE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_good) |-> $past(&chan_good)); // R6

  AST_PG_FALL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(chan_good) & ~chan_good)) |-> !power_good); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_sync |=> (chan_good == '0 && !power_good)); // R9

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
    AST_RISE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_good[i]) |-> $past(qual_done[i] && rail_eff[i])); // R2

    AST_FALL_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_good[i]) |-> $past(glitch_done[i] || !en_sync)); // R4

    AST_GOOD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_good[i] && rail_eff[i] && en_sync) |=> chan_good[i]); // R8
  end

endmodule

bind supply_supervisor_seq sup_checker #(.NUM_CH(NUM_CH)) i_sup_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_sync     (en_sync),
  .rail_eff    (rail_eff),
  .chan_good   (chan_good_o),
  .power_good  (power_good_o),
  .qual_done   (qual_done),
  .glitch_done (glitch_done)
);

// File: tb/test_supply_supervisor_seq.sv
module test_supply_supervisor_seq;

  localparam int Q = 20;
  localparam int G = 5;
  localparam logic [3:0] USED = 4'b1011;  // channel 2 unused (R11)

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b1;
  logic [3:0] rails = 4'b0000;
  logic [3:0] chan_good;
  logic       power_good;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  int    q_cyc[$];
  logic [4:0] q_val[$];
  string q_req[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  supply_supervisor_seq #(
    .NUM_CH(4), .QUAL_CYCLES(Q), .GLITCH_CYCLES(G),
    .SYNC_STAGES(2), .USED_MASK(USED)
  ) i_supply_supervisor_seq (
    .clk(clk), .rst_n(rst_n), .enable_i(enable),
    .rail_ok_i(rails), .chan_good_o(chan_good), .power_good_o(power_good)
  );

  task automatic expect_at(input int c, input logic [3:0] g, input logic pg,
                           input string req);
    q_cyc.push_back(c);
    q_val.push_back({g, pg});
    q_req.push_back(req);
  endtask

  task automatic wait_until(input int c);
    while (cyc != c) @(negedge clk);
  endtask

  // Monitor: pops expectations due in the current cycle and compares
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      int c;
      logic [4:0] e;
      string r;
      c = q_cyc.pop_front();
      e = q_val.pop_front();
      r = q_req.pop_front();
      n_checks++;
      if (c != cyc || {chan_good, power_good} !== e) begin
        n_errors++;
        $display("FAIL %s cyc %0d: got good=%b pg=%b, expected good=%b pg=%b",
                 r, c, chan_good, power_good, e[4:1], e[0]);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int t0, t2, t3, t4, t5, t6, t7, t8, t9;
    t0 = 4;
    t2 = t0 + Q + 15;
    t3 = t2 + Q + 8;
    t4 = t3 + 30;
    t5 = t4 + G + 5;
    t6 = t5 + Q - G;
    t7 = t5 + Q + 5;
    t8 = t7 + Q + 8;
    t9 = t8 + 12;

    expect_at(3, 4'b0000, 0, "R1 reset");
    expect_at(t0+Q+1,  4'b0000, 0, "R2 not yet qualified");
    expect_at(t0+Q+2,  4'b0101, 0, "R2 qualified; R11 unused ch2");
    expect_at(t0+Q+10, 4'b0101, 0, "R3 restart holds ch1");
    expect_at(t0+Q+11, 4'b0111, 0, "R3 ch1 after restart");
    expect_at(t2+Q+1,  4'b0111, 0, "R2 ch3 pending");
    expect_at(t2+Q+2,  4'b1111, 0, "R6 last status, pg lags");
    expect_at(t2+Q+3,  4'b1111, 1, "R6 pg rises");
    expect_at(t3+10,   4'b1111, 1, "R5 short dip ignored");
    expect_at(t3+22,   4'b1111, 1, "R5 second dip ignored");
    expect_at(t4+G+1,  4'b1111, 1, "R4 before glitch window ends");
    expect_at(t4+G+2,  4'b1110, 0, "R4 R7 R8 ch0 falls alone");
    expect_at(t5+Q+2,  4'b1101, 0, "R6 coincident rise and fall");
    expect_at(t5+Q+3,  4'b1101, 0, "R6 pg stays low");
    expect_at(t7+Q+2,  4'b1111, 0, "R6 all good again");
    expect_at(t7+Q+3,  4'b1111, 1, "R6 pg revalidated");
    expect_at(t8+2,    4'b1111, 1, "R9 enable low not yet seen");
    expect_at(t8+3,    4'b0000, 0, "R9 enable low clears");
    expect_at(t8+10,   4'b0000, 0, "R9 rails ignored while disabled");
    expect_at(t9+Q+1,  4'b0000, 0, "R10 before qualification");
    expect_at(t9+Q+2,  4'b1111, 0, "R10 R11 statuses after enable");
    expect_at(t9+Q+3,  4'b1111, 1, "R10 pg after enable");

    @(negedge clk);
    wait_until(t0);    rst_n = 1'b1; rails = 4'b0011;
    wait_until(t0+8);  rails[1] = 1'b0;
    wait_until(t0+9);  rails[1] = 1'b1;
    wait_until(t2);    rails[3] = 1'b1;
    wait_until(t3);    rails[0] = 1'b0;
    wait_until(t3+4);  rails[0] = 1'b1;
    wait_until(t3+12); rails[0] = 1'b0;
    wait_until(t3+16); rails[0] = 1'b1;
    wait_until(t4);    rails[0] = 1'b0;
    wait_until(t5);    rails[0] = 1'b1;
    wait_until(t6);    rails[1] = 1'b0;
    wait_until(t7);    rails[1] = 1'b1;
    wait_until(t8);    enable = 1'b0;
    wait_until(t8+5);  rails[0] = 1'b0;
    wait_until(t8+7);  rails[0] = 1'b1;
    wait_until(t9);    enable = 1'b1;
    wait_until(t9+Q+5);
    if (q_cyc.size() != 0) begin
      n_checks++;
      n_errors++;
      $display("FAIL scoreboard: got %0d pending, expected 0", q_cyc.size());
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule